// File: doc/BRIEF.md
# Credit-Based Wormhole Link Sender

This block drives one router-to-router link. An upstream buffer presents flits one at a time with a valid/ready handshake. Each flit carries a two-bit kind field that marks it as the head, a body part or the tail of a packet. The head flit also carries the destination address in its payload. The sender forwards each flit as soon as the downstream buffer is known to have room. It does not wait for the rest of the packet, so a packet spreads across the path like a worm.

Room at the far end is tracked with credits. A counter starts at the depth of the downstream buffer. It loses one credit for every flit launched and gains one for every single-cycle credit pulse the downstream buffer sends back as it frees a slot. When no credit is held, the sender withdraws its ready signal and launches nothing. No flit is ever dropped: a flit that is not accepted stays with the upstream buffer until it is accepted. All link outputs come straight from registers.

Top module: `wh_link_sender`

## Requirements
- R1: After synchronous reset, `flit_valid_o` is 0, `credits_o` equals the parameter `CRED_DEPTH` (default 4), and `up_ready_o` is 1.
- R2: A flit is accepted on a rising clock edge where `up_valid_i` and `up_ready_o` are both 1. In the following cycle, `flit_valid_o` is 1 and `flit_data_o` and `flit_kind_o` equal the accepted values.
- R3: While `credits_o` is 0, `up_ready_o` is 0, and `flit_valid_o` is 0 in the following cycle.
- R4: Each accepted flit with no credit pulse in the same cycle lowers `credits_o` by one at that edge.
- R5: Each `credit_i` pulse with no accepted flit in the same cycle raises `credits_o` by one at that edge.
- R6: When a flit is accepted and a credit pulse arrives in the same cycle, `credits_o` is unchanged.
- R7: `credits_o` always stays between 0 and `CRED_DEPTH`. With no credits returned, at most `CRED_DEPTH` flits are launched.
- R8: Flits leave in the order they were accepted. A head flit is launched before the rest of its packet has been offered (wormhole forwarding).
- R9: The kind field passes through unaltered for every encoding: 2'b00 body, 2'b01 head, 2'b10 tail, 2'b11 single-flit packet (head and tail at once).
- R10: No flit is lost or duplicated. Every accepted flit appears exactly once on the link, and nothing appears that was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid_i | input | 1 | Upstream flit present |
| up_ready_o | output | 1 | Sender can take a flit this cycle (credit held) |
| up_kind_i | input | 2 | Upstream flit kind (00 body, 01 head, 10 tail, 11 single) |
| up_data_i | input | FLIT_W | Upstream flit payload |
| flit_valid_o | output | 1 | Flit on the link this cycle |
| flit_kind_o | output | 2 | Kind of the launched flit |
| flit_data_o | output | FLIT_W | Payload of the launched flit |
| credit_i | input | 1 | One-cycle pulse: one downstream slot freed |
| credits_o | output | $clog2(CRED_DEPTH+1) | Credits currently held |

## Verification
The checker watches every cycle for the credit arithmetic (decrement, increment, and hold when a launch and a return coincide). It also checks that the counter stays within its bounds, that ready is withdrawn at zero credits, and that a launch follows every acceptance with the same payload and kind and never happens otherwise. Other properties depend on a whole sequence of cycles, and only the bench's directed scenarios show them. These are in-order and loss-free delivery across multi-flit packets, the cap of CRED_DEPTH launches while credits are starved, wormhole launch of a head before its tail is offered, and pass-through of each of the four kind codes.

// File: rtl/wh_link_pkg.sv
package wh_link_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flit_kind_e;

endpackage

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count,
  output logic          nonzero
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (take && !give) begin
      count_nxt = count - 1'b1;
    end else if (give && !take) begin
      count_nxt = count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= FULL;
      nonzero <= (DEPTH != 0);
    end else begin
      count   <= count_nxt;
      nonzero <= (count_nxt != '0);
    end
  end

endmodule

// File: rtl/wh_flit_launch.sv
module wh_flit_launch
  import wh_link_pkg::*;
#(
  parameter int W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [KIND_W-1:0] kind_in,
  input  logic [W-1:0]      data_in,
  output logic              valid_out,
  output logic [KIND_W-1:0] kind_out,
  output logic [W-1:0]      data_out
);

  flit_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
    end else begin
      valid_out <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      kind_q   <= flit_kind_e'(kind_in);
      data_out <= data_in;
    end
  end

  assign kind_out = kind_q;

endmodule

// File: rtl/wh_link_sender.sv
module wh_link_sender
  import wh_link_pkg::*;
#(
  parameter int FLIT_W     = 128,
  parameter int CRED_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              up_valid_i,
  output logic                              up_ready_o,
  input  logic [KIND_W-1:0]                 up_kind_i,
  input  logic [FLIT_W-1:0]                 up_data_i,
  output logic                              flit_valid_o,
  output logic [KIND_W-1:0]                 flit_kind_o,
  output logic [FLIT_W-1:0]                 flit_data_o,
  input  logic                              credit_i,
  output logic [$clog2(CRED_DEPTH+1)-1:0]   credits_o
);

  localparam int CNT_W = $clog2(CRED_DEPTH + 1);

  logic have_credit;
  logic accept;

  assign up_ready_o = have_credit;
  assign accept     = up_valid_i && have_credit;

  wh_credit_ctr #(
    .DEPTH (CRED_DEPTH),
    .CW    (CNT_W)
  ) credit_i0 (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .give    (credit_i),
    .count   (credits_o),
    .nonzero (have_credit)
  );

  wh_flit_launch #(
    .W (FLIT_W)
  ) launch_i0 (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .kind_in   (up_kind_i),
    .data_in   (up_data_i),
    .valid_out (flit_valid_o),
    .kind_out  (flit_kind_o),
    .data_out  (flit_data_o)
  );

endmodule

// File: rtl/wh_link_sender_chk.sv
module wh_link_sender_chk #(
  parameter int W     = 128,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          up_valid_i,
  input logic          up_ready_o,
  input logic [1:0]    up_kind_i,
  input logic [W-1:0]  up_data_i,
  input logic          flit_valid_o,
  input logic [1:0]    flit_kind_o,
  input logic [W-1:0]  flit_data_o,
  input logic          credit_i,
  input logic [CW-1:0] credits_o
);

  logic acc;
  assign acc = up_valid_i && up_ready_o;

  // R1: first cycle out of reset
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int'(credits_o) == DEPTH && !flit_valid_o));

  // R2: launch follows acceptance with the same content
  assert_launch_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> (flit_valid_o && flit_data_o == $past(up_data_i)
             && flit_kind_o == $past(up_kind_i)));

  // R3: no credit, no ready
  assert_ready_low_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (credits_o == '0) |-> !up_ready_o);

  // R3 / R10: no launch without acceptance
  assert_no_spurious_launch_R3: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !flit_valid_o);

  // R4
  assert_credit_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && !credit_i) |=> (int'(credits_o) == int'($past(credits_o)) - 1));

  // R5
  assert_credit_inc_R5: assert property (@(posedge clk) disable iff (rst)
    (!acc && credit_i) |=> (int'(credits_o) == int'($past(credits_o)) + 1));

  // R6
  assert_credit_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (acc == credit_i) |=> $stable(credits_o));

  // R7
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    int'(credits_o) <= DEPTH);

endmodule

bind wh_link_sender wh_link_sender_chk #(
  .W     (FLIT_W),
  .DEPTH (CRED_DEPTH),
  .CW    (CNT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .up_valid_i   (up_valid_i),
  .up_ready_o   (up_ready_o),
  .up_kind_i    (up_kind_i),
  .up_data_i    (up_data_i),
  .flit_valid_o (flit_valid_o),
  .flit_kind_o  (flit_kind_o),
  .flit_data_o  (flit_data_o),
  .credit_i     (credit_i),
  .credits_o    (credits_o)
);

// File: tb/wh_link_sender_tb_top.sv
module wh_link_sender_tb_top;

  localparam int W  = 128;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          up_valid_i;
  logic          up_ready_o;
  logic [1:0]    up_kind_i;
  logic [W-1:0]  up_data_i;
  logic          flit_valid_o;
  logic [1:0]    flit_kind_o;
  logic [W-1:0]  flit_data_o;
  logic          credit_i;
  logic [CW-1:0] credits_o;

  always #10 clk = ~clk;

  wh_link_sender #(.FLIT_W(W), .CRED_DEPTH(D)) dut_i (
    .clk(clk), .rst(rst),
    .up_valid_i(up_valid_i), .up_ready_o(up_ready_o),
    .up_kind_i(up_kind_i), .up_data_i(up_data_i),
    .flit_valid_o(flit_valid_o), .flit_kind_o(flit_kind_o),
    .flit_data_o(flit_data_o),
    .credit_i(credit_i), .credits_o(credits_o)
  );

  int checks = 0;
  int errors = 0;
  int model_cnt = D;
  logic [W+1:0] exp_q[$];
  bit acc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // link monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && flit_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected flit", {flit_kind_o, flit_data_o}, '0);
      end else begin
        logic [W+1:0] e;
        e = exp_q.pop_front();
        chk({flit_kind_o, flit_data_o} == e, "R8", "order/content",
            {flit_kind_o, flit_data_o}, e);
      end
    end
  end

  // one cycle: drive at negedge, evaluate after settling
  task automatic step(input bit v, input logic [1:0] k, input logic [W-1:0] d,
                      input bit cr);
    @(negedge clk);
    up_valid_i = v; up_kind_i = k; up_data_i = d; credit_i = cr;
    #1;
    chk(int'(credits_o) == model_cnt, "R4", "credit count vs model",
        W'(credits_o), W'(model_cnt));
    chk(int'(credits_o) <= D, "R7", "credit bound", W'(credits_o), W'(D));
    if (model_cnt == 0)
      chk(!up_ready_o, "R3", "ready at zero credits", W'(up_ready_o), '0);
    acc = v && up_ready_o;
    if (acc) exp_q.push_back({k, d});
    model_cnt = model_cnt - int'(acc) + int'(cr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, '0, 1'b0);
  endtask

  task automatic refill();
    while (model_cnt < D) step(1'b0, 2'b00, '0, 1'b1);
    idle(1);
  endtask

  task automatic send(input logic [1:0] k, input logic [W-1:0] d);
    step(1'b1, k, d, 1'b0);
    while (!acc) step(1'b1, k, d, 1'b0);
  endtask

  task automatic test_reset();
    rst = 1'b1; up_valid_i = 0; up_kind_i = 0; up_data_i = '0; credit_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk(!flit_valid_o, "R1", "valid after reset", W'(flit_valid_o), '0);
    chk(int'(credits_o) == D, "R1", "credits after reset", W'(credits_o), W'(D));
    chk(up_ready_o, "R1", "ready after reset", W'(up_ready_o), 1);
  endtask

  task automatic test_kinds();
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] d;
      d = {4{32'hA5A5_0000 + 32'(k)}};
      step(1'b1, 2'(k), d, 1'b0);
      step(1'b0, 2'b00, '0, 1'b0);
      chk(flit_valid_o && flit_kind_o == 2'(k), "R9", "kind pass-through",
          W'(flit_kind_o), W'(k));
      chk(flit_data_o == d, "R2", "payload next cycle", flit_data_o, d);
      step(1'b0, 2'b00, '0, 1'b1);
    end
    idle(1);
  endtask

  task automatic test_starve();
    // six-flit packet, no credits returned until stall is observed
    send(2'b01, 128'h1);
    for (int i = 2; i <= 4; i++) send(2'b00, W'(i));
    step(1'b1, 2'b00, W'(5), 1'b0);
    chk(!acc, "R7", "fifth flit held back", W'(acc), '0);
    step(1'b1, 2'b00, W'(5), 1'b0);
    chk(!flit_valid_o, "R3", "no launch at zero credits", W'(flit_valid_o), '0);
    chk(!up_ready_o, "R3", "ready low at zero", W'(up_ready_o), '0);
    step(1'b1, 2'b00, W'(5), 1'b1);
    send(2'b00, W'(5));
    step(1'b0, 2'b00, '0, 1'b1);
    send(2'b10, W'(6));
    refill();
    chk(exp_q.size() == 0, "R10", "all flits delivered", W'(exp_q.size()), '0);
  endtask

  task automatic test_credit_arith();
    send(2'b01, 128'hB0);
    send(2'b00, 128'hB1);
    step(1'b0, 2'b00, '0, 1'b1);
    step(1'b0, 2'b00, '0, 1'b0);
    chk(int'(credits_o) == D - 1, "R5", "credit return raises count",
        W'(credits_o), W'(D - 1));
    step(1'b1, 2'b10, 128'hB2, 1'b1);
    step(1'b0, 2'b00, '0, 1'b0);
    chk(int'(credits_o) == D - 1, "R6", "launch plus return holds count",
        W'(credits_o), W'(D - 1));
    refill();
  endtask

  task automatic test_wormhole();
    step(1'b1, 2'b01, 128'hC0DE, 1'b0);
    step(1'b0, 2'b00, '0, 1'b0);
    chk(flit_valid_o && flit_kind_o == 2'b01, "R8", "head out before tail offered",
        W'(flit_kind_o), 1);
    send(2'b00, 128'hC1);
    send(2'b10, 128'hC2);
    refill();
    chk(exp_q.size() == 0, "R10", "worm fully delivered", W'(exp_q.size()), '0);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_kinds();
    test_starve();
    test_credit_arith();
    test_wormhole();
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule